// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM from power-on to a usable state. It owns the command bus (clock enable, chip select, row strobe, column strobe, write enable, bank address and address) from the release of reset until initialization is complete. First it holds clock enable low for the power-up interval and then high for a short NOP interval. After that it issues, in a fixed order, the extended-mode load that turns the DLL on and the mode load that resets the DLL. Then come a precharge of all banks, two auto refreshes and a final mode load that leaves the DLL reset clear. Each wait is computed from a nanosecond parameter and the clock period. Only NOP is driven while a wait is running.

Burst length, burst type and CAS latency are parameters. They are packed into the mode word that both mode loads carry. When the final mode-register wait ends, a ready flag goes high. A second flag, which permits reads, goes high only after a fixed number of cycles has passed since the DLL-reset command. A controller that takes over the bus after ready therefore still holds back READ until that flag is set.

Top module: `ddr_init_seq`

## Requirements
- R1: While rst_n is low (asynchronous), cke is 0, the bus carries NOP, and ready and read_ok are 0. Every counter restarts, and the sequence begins again from the power-up wait when reset is released.
- R2: cke stays 0 for PWR = ceil(T_PWRUP_NS/tCK) cycles after reset release. It is 1 from cycle PWR onward and never falls again until the next reset.
- R3: The command code on {cs_n, ras_n, cas_n, we_n} is 0111 for NOP, 0000 for load-mode, 0010 for precharge and 0001 for auto refresh.
- R4: The non-NOP commands come in exactly this order: extended-mode load, mode load with DLL reset, precharge, refresh, refresh, mode load. No other command follows them.
- R5: The extended-mode load uses ba = 01 and addr = 0, so A0 = 0 enables the DLL.
- R6: A mode load uses ba = 00. A2..A0 hold the burst-length code (2 gives 001, 4 gives 010, 8 gives 011), and A3 holds the burst type (0 sequential, 1 interleaved). A6..A4 hold the CAS-latency code (2 gives 010, 2.5 gives 110, 3 gives 011). A8 is 1 in the first mode load and 0 in the second, and every other bit is 0.
- R7: The precharge command has A10 = 1 (all banks).
- R8: The first command comes in cycle PWR + ceil(T_CKE_NOP_NS/tCK). Each later command comes exactly N+1 cycles after the one before it, with only NOP in between. N = max(1, ceil(t/tCK)), where t is tMRD after a load, tRP after a precharge and tRFC after a refresh.
- R9: ready rises MRD+1 cycles after the final mode load. It then stays 1, and the bus stays at NOP.
- R10: read_ok rises exactly DLL_LOCK_CYC cycles after the cycle that carries the DLL-reset mode load, and it then stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the SDRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address / mode word |
| ready | output | 1 | Initialization sequence finished |
| read_ok | output | 1 | DLL lock interval elapsed; READ may be issued |

## Verification
The only inputs are the clock and the reset, so the assertions assume no more than a clock that keeps running and a reset that can arrive at any time. Reset is asserted away from the clock edge. The stimulus asserts reset once after a complete run and once in the middle of a run, after the DLL-reset command but before lock. Each time, a fresh expected sequence is queued, so the aborted run can never satisfy the checks of the run that follows it. Three instances with different burst and latency parameters cover the mode-word encodings.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef logic [3:0] cmd_t;  // {cs_n, ras_n, cas_n, we_n}

  localparam cmd_t CMD_NOP = 4'b0111;
  localparam cmd_t CMD_LMR = 4'b0000;
  localparam cmd_t CMD_PRE = 4'b0010;
  localparam cmd_t CMD_REF = 4'b0001;

  typedef enum logic [3:0] {
    ST_PWRUP, ST_CKE_NOP, ST_EXT_LD, ST_EXT_WT, ST_MRS_RST, ST_MRS_RST_WT,
    ST_PRE_ALL, ST_PRE_WT, ST_REF_A, ST_REF_A_WT, ST_REF_B, ST_REF_B_WT,
    ST_MRS_FIN, ST_MRS_FIN_WT, ST_DONE
  } seq_state_e;

  // Cycles covering ns at the given period, never below one.
  function automatic int wait_cycles(input int ns, input int period_ps);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [2:0] burst_code(input int len);
    case (len)
      2:       return 3'b001;
      4:       return 3'b010;
      8:       return 3'b011;
      default: return 3'b000;
    endcase
  endfunction

  // Latency given in half cycles: 4 = 2, 5 = 2.5, 6 = 3.
  function automatic logic [2:0] latency_code(input int lat_x2);
    case (lat_x2)
      4:       return 3'b010;
      5:       return 3'b110;
      6:       return 3'b011;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] last,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    done   = (cnt_q == last);
    cnt_en = clr || !done;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ddr_dll_gate.sv
module ddr_dll_gate #(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic read_ok
);
  localparam int W = $clog2(LOCK_CYC + 1);
  localparam logic [W-1:0] LOCK_V = W'(LOCK_CYC);

  logic [W-1:0] lock_q;
  logic [W-1:0] lock_d;
  logic         lock_en;

  always_comb begin
    lock_en = start || ((lock_q != '0) && (lock_q != LOCK_V));
    lock_d  = start ? W'(1) : lock_q + 1'b1;
    read_ok = (lock_q == LOCK_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= '0;
    else if (lock_en) lock_q <= lock_d;
  end

  p_lock_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q <= LOCK_V);
  p_readok_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |=> read_ok);
endmodule

// File: rtl/ddr_mode_word.sv
module ddr_mode_word
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W           = 12,
  parameter int BURST_LEN        = 4,
  parameter int BURST_INTERLEAVE = 0,
  parameter int CAS_LAT_X2       = 5
) (
  input  logic              dll_rst,
  output logic [ADDR_W-1:0] word
);
  localparam logic [2:0] BL_C = burst_code(BURST_LEN);
  localparam logic [2:0] CL_C = latency_code(CAS_LAT_X2);
  localparam logic       BT_C = (BURST_INTERLEAVE != 0);

  generate
    if (BL_C == 3'b000) begin : g_bad_len
      $error("burst length must be 2, 4 or 8");
    end
    if (CL_C == 3'b000) begin : g_bad_lat
      $error("CAS latency must be 2, 2.5 or 3");
    end
  endgenerate

  always_comb begin
    word      = '0;
    word[2:0] = BL_C;
    word[3]   = BT_C;
    word[6:4] = CL_C;
    word[8]   = dll_rst;
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int CLK_PERIOD_PS    = 20000,
  parameter int ADDR_W           = 12,
  parameter int BA_W             = 2,
  parameter int T_PWRUP_NS       = 200000,
  parameter int T_CKE_NOP_NS     = 400,
  parameter int T_RP_NS          = 20,
  parameter int T_RFC_NS         = 80,
  parameter int T_MRD_NS         = 15,
  parameter int DLL_LOCK_CYC     = 200,
  parameter int BURST_LEN        = 4,
  parameter int BURST_INTERLEAVE = 0,
  parameter int CAS_LAT_X2       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic              read_ok
);
  localparam int PWR_C = wait_cycles(T_PWRUP_NS, CLK_PERIOD_PS);
  localparam int CKE_C = wait_cycles(T_CKE_NOP_NS, CLK_PERIOD_PS);
  localparam int RP_C  = wait_cycles(T_RP_NS, CLK_PERIOD_PS);
  localparam int RFC_C = wait_cycles(T_RFC_NS, CLK_PERIOD_PS);
  localparam int MRD_C = wait_cycles(T_MRD_NS, CLK_PERIOD_PS);
  localparam int MAX_A = (PWR_C > CKE_C) ? PWR_C : CKE_C;
  localparam int MAX_B = (RP_C > RFC_C) ? RP_C : RFC_C;
  localparam int MAX_C = (MAX_B > MRD_C) ? MAX_B : MRD_C;
  localparam int MAX_W = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CNT_W = $clog2(MAX_W + 1);
  localparam int AP_BIT = 10;

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] wait_last;
  logic             wait_done;
  logic             wait_clr;
  logic             mw_dll_rst;
  logic [ADDR_W-1:0] mode_w;
  cmd_t             cmd;

  // Next-state process
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_PWRUP:      if (wait_done) st_d = ST_CKE_NOP;
      ST_CKE_NOP:    if (wait_done) st_d = ST_EXT_LD;
      ST_EXT_LD:     st_d = ST_EXT_WT;
      ST_EXT_WT:     if (wait_done) st_d = ST_MRS_RST;
      ST_MRS_RST:    st_d = ST_MRS_RST_WT;
      ST_MRS_RST_WT: if (wait_done) st_d = ST_PRE_ALL;
      ST_PRE_ALL:    st_d = ST_PRE_WT;
      ST_PRE_WT:     if (wait_done) st_d = ST_REF_A;
      ST_REF_A:      st_d = ST_REF_A_WT;
      ST_REF_A_WT:   if (wait_done) st_d = ST_REF_B;
      ST_REF_B:      st_d = ST_REF_B_WT;
      ST_REF_B_WT:   if (wait_done) st_d = ST_MRS_FIN;
      ST_MRS_FIN:    st_d = ST_MRS_FIN_WT;
      ST_MRS_FIN_WT: if (wait_done) st_d = ST_DONE;
      default:       st_d = ST_DONE;
    endcase
    wait_clr = (st_d != st_q);
  end

  // Wait length for the current state
  always_comb begin
    case (st_q)
      ST_PWRUP:                              wait_last = CNT_W'(PWR_C - 1);
      ST_CKE_NOP:                            wait_last = CNT_W'(CKE_C - 1);
      ST_EXT_WT, ST_MRS_RST_WT, ST_MRS_FIN_WT: wait_last = CNT_W'(MRD_C - 1);
      ST_PRE_WT:                             wait_last = CNT_W'(RP_C - 1);
      ST_REF_A_WT, ST_REF_B_WT:              wait_last = CNT_W'(RFC_C - 1);
      default:                               wait_last = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_PWRUP;
    else        st_q <= st_d;
  end

  ddr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(wait_clr), .last(wait_last), .done(wait_done)
  );

  assign mw_dll_rst = (st_q == ST_MRS_RST);

  ddr_mode_word #(
    .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN),
    .BURST_INTERLEAVE(BURST_INTERLEAVE), .CAS_LAT_X2(CAS_LAT_X2)
  ) u_mode (
    .dll_rst(mw_dll_rst), .word(mode_w)
  );

  ddr_dll_gate #(.LOCK_CYC(DLL_LOCK_CYC)) u_dll (
    .clk(clk), .rst_n(rst_n), .start(mw_dll_rst), .read_ok(read_ok)
  );

  // Bus decode from the state register
  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    case (st_q)
      ST_EXT_LD: begin cmd = CMD_LMR; ba = BA_W'(1); end
      ST_MRS_RST, ST_MRS_FIN: begin cmd = CMD_LMR; addr = mode_w; end
      ST_PRE_ALL: begin cmd = CMD_PRE; addr[AP_BIT] = 1'b1; end
      ST_REF_A, ST_REF_B: cmd = CMD_REF;
      default: ;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke   = (st_q != ST_PWRUP);
  assign ready = (st_q == ST_DONE);

  p_cmd_then_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} != CMD_NOP) |=> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));
  p_cke_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  p_cmd_needs_cke_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} != CMD_NOP) |-> cke);
  p_ready_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  p_idle_after_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));
endmodule

// File: tb/ddr_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_init_seq_tb_top;
  localparam int PER_PS = 20000;
  localparam logic [3:0] C_NOP = 4'b0111, C_LMR = 4'b0000, C_PRE = 4'b0010, C_REF = 4'b0001;

  function automatic int cyc_of(input int ns);
    int c;
    c = (ns * 1000 + PER_PS - 1) / PER_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int PWR   = cyc_of(200000);
  localparam int CKEC  = cyc_of(400);
  localparam int RP    = cyc_of(20);
  localparam int RFC   = cyc_of(80);
  localparam int MRD   = cyc_of(15);
  localparam int T_EXT = PWR + CKEC;
  localparam int T_MRR = T_EXT + MRD + 1;
  localparam int T_PRE = T_MRR + MRD + 1;
  localparam int T_RF1 = T_PRE + RP + 1;
  localparam int T_RF2 = T_RF1 + RFC + 1;
  localparam int T_MRF = T_RF2 + RFC + 1;
  localparam int T_RDY = T_MRF + MRD + 1;
  localparam int T_LCK = T_MRR + 200;

  typedef struct {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [11:0] mask;
    int          cyc;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic cke, cs_n, ras_n, cas_n, we_n, ready, read_ok;
  logic [1:0] ba;
  logic [11:0] addr;
  logic a1_cke, a1_cs, a1_ras, a1_cas, a1_we, a1_rdy, a1_rok;
  logic [1:0] a1_ba;
  logic [11:0] a1_addr;
  logic a2_cke, a2_cs, a2_ras, a2_cas, a2_we, a2_rdy, a2_rok;
  logic [1:0] a2_ba;
  logic [11:0] a2_addr;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ddr_init_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .ready(ready), .read_ok(read_ok));

  ddr_init_seq #(.T_PWRUP_NS(1000), .BURST_LEN(8), .BURST_INTERLEAVE(1), .CAS_LAT_X2(6)) alt1_i (
    .clk(clk), .rst_n(rst_n), .cke(a1_cke), .cs_n(a1_cs), .ras_n(a1_ras), .cas_n(a1_cas),
    .we_n(a1_we), .ba(a1_ba), .addr(a1_addr), .ready(a1_rdy), .read_ok(a1_rok));

  ddr_init_seq #(.T_PWRUP_NS(1000), .BURST_LEN(2), .BURST_INTERLEAVE(0), .CAS_LAT_X2(4)) alt2_i (
    .clk(clk), .rst_n(rst_n), .cke(a2_cke), .cs_n(a2_cs), .ras_n(a2_ras), .cas_n(a2_cas),
    .we_n(a2_we), .ba(a2_ba), .addr(a2_addr), .ready(a2_rdy), .read_ok(a2_rok));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a,
                      input logic [11:0] m, input int t, input string tag);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.mask = m; e.cyc = t; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Driver: expected command stream of one complete run (R4 order)
  task automatic push_run();
    sb_q.delete();
    push(C_LMR, 2'b01, 12'h000, 12'hFFF, T_EXT, "R5");
    push(C_LMR, 2'b00, 12'h162, 12'hFFF, T_MRR, "R6");
    push(C_PRE, 2'b00, 12'h400, 12'h400, T_PRE, "R7");
    push(C_REF, 2'b00, 12'h000, 12'h000, T_RF1, "R4");
    push(C_REF, 2'b00, 12'h000, 12'h000, T_RF2, "R4");
    push(C_LMR, 2'b00, 12'h062, 12'hFFF, T_MRF, "R6");
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  // Monitor: pop and compare
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      logic [3:0] c;
      c = {cs_n, ras_n, cas_n, we_n};
      if (c != C_NOP) begin
        if (sb_q.size() == 0) begin
          check(0, "R4", "unexpected command", c, C_NOP);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(c == e.cmd, "R3", {e.tag, " command code"}, c, e.cmd);
          check(ba == e.ba, e.tag, "bank address", ba, e.ba);
          check((addr & e.mask) == (e.addr & e.mask), e.tag, "address word", addr & e.mask, e.addr & e.mask);
          check(cyc == e.cyc, "R8", {e.tag, " issue cycle"}, cyc, e.cyc);
        end
      end
      if (cyc == PWR - 1) check(cke == 1'b0, "R2", "cke before power-up end", cke, 0);
      if (cyc == PWR)     check(cke == 1'b1, "R2", "cke after power-up end", cke, 1);
      if (cyc == T_RDY - 1) check(ready == 1'b0, "R9", "ready early", ready, 0);
      if (cyc == T_RDY)     check(ready == 1'b1, "R9", "ready rise", ready, 1);
      if (cyc == T_LCK - 1) check(read_ok == 1'b0, "R10", "read_ok early", read_ok, 0);
      if (cyc == T_LCK)     check(read_ok == 1'b1, "R10", "read_ok rise", read_ok, 1);
      if ({a1_cs, a1_ras, a1_cas, a1_we} == C_LMR && a1_ba == 2'b00)
        check((a1_addr & 12'hEFF) == 12'h03B, "R6", "alt1 mode word", a1_addr & 12'hEFF, 12'h03B);
      if ({a2_cs, a2_ras, a2_cas, a2_we} == C_LMR && a2_ba == 2'b00)
        check((a2_addr & 12'hEFF) == 12'h021, "R6", "alt2 mode word", a2_addr & 12'hEFF, 12'h021);
    end
  end

  task automatic check_reset_state(input string when);
    check(cke == 1'b0, "R1", {when, " cke"}, cke, 0);
    check({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1", {when, " bus"}, {cs_n, ras_n, cas_n, we_n}, C_NOP);
    check(ready == 1'b0, "R1", {when, " ready"}, ready, 0);
    check(read_ok == 1'b0, "R1", {when, " read_ok"}, read_ok, 0);
  endtask

  task automatic release_reset();
    @(negedge clk);
    #2 rst_n = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic assert_reset();
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
  endtask

  initial begin
    #(200000 * 20);
    check(0, "R4", "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state("initial reset");
    push_run();
    release_reset();
    wait_cyc(T_LCK + 5);
    @(negedge clk);
    check(sb_q.size() == 0, "R4", "commands left after run", sb_q.size(), 0);
    check(ready && read_ok, "R10", "flags held", {ready, read_ok}, 3);

    // Reset after a complete run, then abort mid-run
    assert_reset();
    check_reset_state("reset after run");
    push_run();
    release_reset();
    wait_cyc(T_MRR + 10);
    @(negedge clk);
    check(read_ok == 1'b0, "R10", "read_ok during lock", read_ok, 0);
    assert_reset();
    check_reset_state("mid-run reset");

    // Fresh run after abort must restart from power-up
    push_run();
    release_reset();
    wait_cyc(T_LCK + 5);
    @(negedge clk);
    check(sb_q.size() == 0, "R4", "commands left after restart", sb_q.size(), 0);
    check(ready == 1'b1, "R9", "ready after restart", ready, 1);
    finish_up();
  end
endmodule